// File: doc/BRIEF.md
# Additive Checksum Payload Framer

This block sits between a byte-stream payload interface and the serial engine that moves bytes to and from a short-range radio. On the transmit side it passes a frame of N payload bytes from a valid/ready input stream to a valid/ready output stream. When the checksum option is on, it then emits one extra byte: the 8-bit modular sum of the payload. On the receive side it takes the bytes that come back from the radio. It passes the first N of them on as payload and, with the checksum on, compares the sum it has computed against the trailing byte. It then reports the result as pass or fail.

The frame length and the checksum option are configuration inputs. Each direction latches them when its frame starts. A length that does not fit the radio's payload buffer is flagged, and a start request with such a length is refused. The block also reports the receive width that software must program for every receive pipe of the radio, which is the payload length plus one byte when the checksum is on.

Top module: `csum_framer`

## Requirements
- R1: The checksum is the sum of all payload bytes of a frame, modulo 256, starting from zero.
- R2: A transmit frame forwards exactly N input bytes to the output in order, with the output valid and data following the input in the same cycle. With the checksum on, the next output byte is the checksum, after which the path goes idle. With it off, the path goes idle right after byte N.
- R3: With the checksum on, a receive frame forwards the first N bytes on the payload output and does not forward byte N+1. The result flag is 1 exactly when byte N+1 equals the sum of the first N.
- R4: With the checksum off, a receive frame takes N bytes and always reports pass (result flag 1).
- R5: `cfg_bad` is 0 for lengths 1 to 32 with the checksum off, and for lengths 1 to 31 with it on. It is 1 for every other length.
- R6: A start request while `cfg_bad` is 1 raises the matching reject output for exactly the following cycle. The path stays idle: it sends no bytes and accepts no input.
- R7: `pipe_width` equals `cfg_len` plus the checksum enable bit, whenever the configuration is legal.
- R8: The receive result becomes valid in the cycle after the final byte is taken. It stays valid and unchanged until the next accepted receive start, which clears it.
- R9: While `tx_out_ready` is low, no input byte is consumed, and a pending checksum byte stays on the output unchanged until it is accepted.
- R10: After reset both paths are idle, with no output valid, no reject and no result valid.
- R11: A start request while a path is busy is ignored, and the running frame keeps its latched length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | LEN_W | Payload length N in bytes |
| cfg_csum_en | input | 1 | 1 appends and checks a checksum byte |
| cfg_bad | output | 1 | Configured length is out of the legal range |
| pipe_width | output | LEN_W | Receive width to program per pipe |
| tx_start | input | 1 | Request to begin a transmit frame |
| tx_in_valid | input | 1 | Payload byte offered |
| tx_in_data | input | DATA_W | Payload byte |
| tx_in_ready | output | 1 | Payload byte taken this cycle if valid |
| tx_out_valid | output | 1 | Byte offered to the serial engine |
| tx_out_data | output | DATA_W | Payload or checksum byte |
| tx_out_ready | input | 1 | Serial engine takes the byte |
| tx_busy | output | 1 | Transmit frame in progress |
| tx_reject | output | 1 | Previous-cycle start refused |
| rx_start | input | 1 | Request to begin a receive frame |
| rx_in_valid | input | 1 | Byte from the serial engine |
| rx_in_data | input | DATA_W | Received byte |
| rx_out_valid | output | 1 | Payload byte forwarded |
| rx_out_data | output | DATA_W | Forwarded payload byte |
| rx_res_valid | output | 1 | Frame result available |
| rx_res_ok | output | 1 | 1 pass, 0 checksum mismatch |
| rx_busy | output | 1 | Receive frame in progress |
| rx_reject | output | 1 | Previous-cycle start refused |

## Verification
The bench builds the block with its defaults: 8-bit bytes and a 32-byte buffer limit, which gives a 6-bit length field. With these values the 31/32 boundary on either side of the checksum option can be reached, along with lengths 0 and 33, which the field can still express. A 31-byte frame of 0xFF bytes drives the 8-bit sum through many wraparounds. Length-1 frames exercise the counter compare at its smallest value.

// File: rtl/cf_pkg.sv
package cf_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_CKS  = 2'd2
   } cf_phase_t;

endpackage

// File: rtl/cf_sum_acc.sv
module cf_sum_acc #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] sum
);

   logic [DATA_W-1:0] acc_q;

   // carries beyond DATA_W bits fall off: modular sum
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clr)
         acc_q <= '0;
      else if (add)
         acc_q <= acc_q + din;
   end

   assign sum = acc_q;

endmodule

// File: rtl/cf_len_check.sv
module cf_len_check #(
   parameter int MAX_LEN = 32,
   parameter int LEN_W   = 6
) (
   input  logic [LEN_W-1:0] len,
   input  logic             csum_en,
   output logic             legal,
   output logic [LEN_W-1:0] width
);

   localparam logic [LEN_W-1:0] LimPlain = LEN_W'(MAX_LEN);
   localparam logic [LEN_W-1:0] LimCsum  = LEN_W'(MAX_LEN - 1);

   logic [LEN_W-1:0] limit;

   assign limit = csum_en ? LimCsum : LimPlain;
   assign legal = (len != '0) && (len <= limit);
   assign width = len + LEN_W'(csum_en);

   always_comb begin
      if (legal) begin
         a_r7_width_fits: assert (width <= LimPlain && width >= len)
            else $error("pipe width out of buffer range");
      end
   end

endmodule

// File: rtl/cf_tx_path.sv
module cf_tx_path
   import cf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_en,
   input  logic              cfg_ok,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready,
   output logic              busy,
   output logic              rej
);

   cf_phase_t         phase_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  len_q;
   logic              en_q;
   logic              rej_q;
   logic              start_go;
   logic              fire;
   logic              last;
   logic [DATA_W-1:0] sum;

   assign start_go = start && (phase_q == PH_IDLE) && cfg_ok;
   assign fire     = (phase_q == PH_DATA) && in_valid && out_ready;
   assign last     = (cnt_q == len_q - LEN_W'(1));

   cf_sum_acc #(.DATA_W(DATA_W)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (start_go),
      .add  (fire),
      .din  (in_data),
      .sum  (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         en_q    <= 1'b0;
         rej_q   <= 1'b0;
      end else begin
         rej_q <= start && (phase_q == PH_IDLE) && !cfg_ok;
         case (phase_q)
            PH_IDLE: begin
               if (start_go) begin
                  phase_q <= PH_DATA;
                  cnt_q   <= '0;
                  len_q   <= cfg_len;
                  en_q    <= cfg_en;
               end
            end
            PH_DATA: begin
               if (fire) begin
                  cnt_q <= cnt_q + LEN_W'(1);
                  if (last)
                     phase_q <= en_q ? PH_CKS : PH_IDLE;
               end
            end
            PH_CKS: begin
               if (out_ready)
                  phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign in_ready  = (phase_q == PH_DATA) && out_ready;
   assign out_valid = ((phase_q == PH_DATA) && in_valid) || (phase_q == PH_CKS);
   assign out_data  = (phase_q == PH_CKS) ? sum : in_data;
   assign busy      = (phase_q != PH_IDLE);
   assign rej       = rej_q;

   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA) |-> (cnt_q < len_q))
      else $error("transmit count passed frame length");

   a_r9_hold_cks: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CKS && !out_ready) |=> (out_valid && $stable(out_data)))
      else $error("checksum byte dropped under backpressure");

   a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rej_q |-> (!out_valid && !in_ready))
      else $error("refused frame moved data");

endmodule

// File: rtl/cf_rx_path.sv
module cf_rx_path
   import cf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_en,
   input  logic              cfg_ok,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              res_valid,
   output logic              res_ok,
   output logic              busy,
   output logic              rej
);

   cf_phase_t         phase_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  len_q;
   logic              en_q;
   logic              rej_q;
   logic              resv_q;
   logic              resok_q;
   logic              start_go;
   logic              take;
   logic              last;
   logic [DATA_W-1:0] sum;

   assign start_go = start && (phase_q == PH_IDLE) && cfg_ok;
   assign take     = (phase_q == PH_DATA) && in_valid;
   assign last     = (cnt_q == len_q - LEN_W'(1));

   cf_sum_acc #(.DATA_W(DATA_W)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (start_go),
      .add  (take),
      .din  (in_data),
      .sum  (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         en_q    <= 1'b0;
         rej_q   <= 1'b0;
         resv_q  <= 1'b0;
         resok_q <= 1'b0;
      end else begin
         rej_q <= start && (phase_q == PH_IDLE) && !cfg_ok;
         case (phase_q)
            PH_IDLE: begin
               if (start_go) begin
                  phase_q <= PH_DATA;
                  cnt_q   <= '0;
                  len_q   <= cfg_len;
                  en_q    <= cfg_en;
                  resv_q  <= 1'b0;
                  resok_q <= 1'b0;
               end
            end
            PH_DATA: begin
               if (take) begin
                  cnt_q <= cnt_q + LEN_W'(1);
                  if (last) begin
                     if (en_q) begin
                        phase_q <= PH_CKS;
                     end else begin
                        phase_q <= PH_IDLE;
                        resv_q  <= 1'b1;
                        resok_q <= 1'b1;
                     end
                  end
               end
            end
            PH_CKS: begin
               if (in_valid) begin
                  phase_q <= PH_IDLE;
                  resv_q  <= 1'b1;
                  resok_q <= (sum == in_data);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign out_valid = take;
   assign out_data  = in_data;
   assign res_valid = resv_q;
   assign res_ok    = resok_q;
   assign busy      = (phase_q != PH_IDLE);
   assign rej       = rej_q;

   a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (resv_q && !start_go) |=> (resv_q && $stable(resok_q)))
      else $error("receive result lost before next frame");

   a_r4_pass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (resv_q && !en_q) |-> resok_q)
      else $error("failure reported with checksum off");

   a_r8_idle_with_result: assert property (@(posedge clk) disable iff (!rst_n)
      resv_q |-> (phase_q == PH_IDLE))
      else $error("result valid during a frame");

endmodule

// File: rtl/csum_framer.sv
module csum_framer #(
   parameter int DATA_W  = 8,
   parameter int MAX_LEN = 32,
   parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_csum_en,
   output logic              cfg_bad,
   output logic [LEN_W-1:0]  pipe_width,
   input  logic              tx_start,
   input  logic              tx_in_valid,
   input  logic [DATA_W-1:0] tx_in_data,
   output logic              tx_in_ready,
   output logic              tx_out_valid,
   output logic [DATA_W-1:0] tx_out_data,
   input  logic              tx_out_ready,
   output logic              tx_busy,
   output logic              tx_reject,
   input  logic              rx_start,
   input  logic              rx_in_valid,
   input  logic [DATA_W-1:0] rx_in_data,
   output logic              rx_out_valid,
   output logic [DATA_W-1:0] rx_out_data,
   output logic              rx_res_valid,
   output logic              rx_res_ok,
   output logic              rx_busy,
   output logic              rx_reject
);

   generate
      if (MAX_LEN < 2) begin : g_chk_len
         $fatal(1, "MAX_LEN must leave room for a checksum byte");
      end
      if ((1 << LEN_W) <= MAX_LEN) begin : g_chk_lenw
         $fatal(1, "LEN_W too narrow for MAX_LEN");
      end
      if (DATA_W < 1) begin : g_chk_dw
         $fatal(1, "DATA_W must be positive");
      end
   endgenerate

   logic len_ok;

   cf_len_check #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
      .len    (cfg_len),
      .csum_en(cfg_csum_en),
      .legal  (len_ok),
      .width  (pipe_width)
   );

   assign cfg_bad = !len_ok;

   cf_tx_path #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tx_start),
      .cfg_len  (cfg_len),
      .cfg_en   (cfg_csum_en),
      .cfg_ok   (len_ok),
      .in_valid (tx_in_valid),
      .in_data  (tx_in_data),
      .in_ready (tx_in_ready),
      .out_valid(tx_out_valid),
      .out_data (tx_out_data),
      .out_ready(tx_out_ready),
      .busy     (tx_busy),
      .rej      (tx_reject)
   );

   cf_rx_path #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (rx_start),
      .cfg_len  (cfg_len),
      .cfg_en   (cfg_csum_en),
      .cfg_ok   (len_ok),
      .in_valid (rx_in_valid),
      .in_data  (rx_in_data),
      .out_valid(rx_out_valid),
      .out_data (rx_out_data),
      .res_valid(rx_res_valid),
      .res_ok   (rx_res_ok),
      .busy     (rx_busy),
      .rej      (rx_reject)
   );

   a_r6_tx_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reject |-> !tx_busy)
      else $error("transmit frame began on a refused start");

   a_r6_rx_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reject |-> !rx_busy)
      else $error("receive frame began on a refused start");

endmodule

// File: tb/test_csum_framer.sv
`timescale 1ns/1ps
module test_csum_framer;

   localparam int DW = 8;
   localparam int LW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] cfg_len = '0;
   logic          cfg_csum_en = 1'b0;
   logic          cfg_bad;
   logic [LW-1:0] pipe_width;
   logic          tx_start = 1'b0;
   logic          tx_in_valid = 1'b0;
   logic [DW-1:0] tx_in_data = '0;
   logic          tx_in_ready;
   logic          tx_out_valid;
   logic [DW-1:0] tx_out_data;
   logic          tx_out_ready = 1'b1;
   logic          tx_busy;
   logic          tx_reject;
   logic          rx_start = 1'b0;
   logic          rx_in_valid = 1'b0;
   logic [DW-1:0] rx_in_data = '0;
   logic          rx_out_valid;
   logic [DW-1:0] rx_out_data;
   logic          rx_res_valid;
   logic          rx_res_ok;
   logic          rx_busy;
   logic          rx_reject;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;
   logic [7:0] pay [0:31];

   always #2.5 clk = ~clk;

   csum_framer i_csum_framer (
      .clk, .rst_n, .cfg_len, .cfg_csum_en, .cfg_bad, .pipe_width,
      .tx_start, .tx_in_valid, .tx_in_data, .tx_in_ready,
      .tx_out_valid, .tx_out_data, .tx_out_ready, .tx_busy, .tx_reject,
      .rx_start, .rx_in_valid, .rx_in_data, .rx_out_valid, .rx_out_data,
      .rx_res_valid, .rx_res_ok, .rx_busy, .rx_reject
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   task automatic fill(input int n, input int seed, input int stride);
      for (int i = 0; i < n; i++) pay[i] = 8'((seed + i * stride) & 8'hFF);
   endtask

   function automatic logic [7:0] ref_sum(input int n);
      int s = 0;
      for (int i = 0; i < n; i++) s = (s + pay[i]) % 256;
      return 8'(s);
   endfunction

   task automatic reset_state;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      chk(!tx_busy && !rx_busy, "R10", "busy after reset", {tx_busy, rx_busy}, 0);
      chk(!tx_out_valid && !rx_out_valid, "R10", "valid after reset", {tx_out_valid, rx_out_valid}, 0);
      chk(!rx_res_valid && !tx_reject && !rx_reject, "R10", "result/reject after reset",
          {rx_res_valid, tx_reject, rx_reject}, 0);
   endtask

   task automatic width_case(input int len, input bit en, input bit bad_exp);
      cfg_len = LW'(len);
      cfg_csum_en = en;
      #1;
      chk(cfg_bad == bad_exp, "R5", $sformatf("cfg_bad len=%0d en=%0d", len, en), cfg_bad, bad_exp);
      if (!bad_exp)
         chk(pipe_width == LW'(len + en), "R7", "pipe_width", pipe_width, len + en);
   endtask

   task automatic test_widths;
      width_case(5, 0, 0);
      width_case(5, 1, 0);
      width_case(31, 1, 0);
      width_case(32, 1, 1);
      width_case(32, 0, 0);
      width_case(1, 1, 0);
      width_case(0, 0, 1);
      width_case(33, 0, 1);
   endtask

   task automatic tx_begin(input int n, input bit en);
      cfg_len = LW'(n);
      cfg_csum_en = en;
      tx_start = 1'b1;
      step();
      tx_start = 1'b0;
      chk(tx_busy, "R2", "tx busy after start", tx_busy, 1);
   endtask

   // poke: pulse a second start mid-frame with a shorter length
   task automatic tx_frame(input int n, input bit en, input bit poke);
      logic [7:0] s;
      tx_begin(n, en);
      for (int i = 0; i < n; i++) begin
         tx_in_valid = 1'b1;
         tx_in_data  = pay[i];
         if (poke && i == 1) begin
            tx_start = 1'b1;
            cfg_len  = LW'(1);
         end
         #1;
         chk(tx_out_valid && tx_in_ready, "R2", "tx pass handshake", {tx_out_valid, tx_in_ready}, 3);
         chk(tx_out_data == pay[i], "R2", $sformatf("tx byte %0d", i), tx_out_data, pay[i]);
         chk(tx_busy, poke ? "R11" : "R2", "tx busy mid frame", tx_busy, 1);
         step();
         tx_start = 1'b0;
      end
      tx_in_valid = 1'b0;
      s = ref_sum(n);
      #1;
      if (en) begin
         chk(tx_out_valid, "R2", "checksum byte valid", tx_out_valid, 1);
         chk(!tx_in_ready, "R2", "no input during checksum", tx_in_ready, 0);
         chk(tx_out_data == s, "R1", "checksum value", tx_out_data, s);
         step();
      end
      chk(!tx_busy && !tx_out_valid, "R2", "tx idle after frame", {tx_busy, tx_out_valid}, 0);
   endtask

   task automatic test_tx_backpressure;
      logic [7:0] s;
      fill(3, 8'h40, 9);
      s = ref_sum(3);
      tx_begin(3, 1);
      tx_in_valid  = 1'b1;
      tx_in_data   = pay[0];
      tx_out_ready = 1'b0;
      #1;
      chk(tx_out_valid && !tx_in_ready, "R9", "stall holds input", {tx_out_valid, tx_in_ready}, 2);
      step();
      step();
      chk(tx_out_data == pay[0], "R9", "stalled byte still offered", tx_out_data, pay[0]);
      tx_out_ready = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tx_in_data = pay[i];
         #1;
         chk(tx_in_ready, "R9", "ready after release", tx_in_ready, 1);
         step();
      end
      tx_in_valid  = 1'b0;
      tx_out_ready = 1'b0;
      #1;
      chk(tx_out_valid && tx_out_data == s, "R9", "checksum offered", tx_out_data, s);
      step();
      step();
      chk(tx_out_valid && tx_busy, "R9", "checksum held", {tx_out_valid, tx_busy}, 3);
      chk(tx_out_data == s, "R9", "checksum unchanged", tx_out_data, s);
      tx_out_ready = 1'b1;
      step();
      chk(!tx_busy, "R9", "idle once taken", tx_busy, 0);
   endtask

   task automatic test_reject;
      cfg_len = LW'(32);
      cfg_csum_en = 1'b1;
      tx_start = 1'b1;
      rx_start = 1'b1;
      step();
      tx_start = 1'b0;
      rx_start = 1'b0;
      chk(tx_reject && rx_reject, "R6", "reject pulse", {tx_reject, rx_reject}, 3);
      chk(!tx_busy && !rx_busy, "R6", "stays idle", {tx_busy, rx_busy}, 0);
      tx_in_valid = 1'b1;
      tx_in_data  = 8'h5A;
      rx_in_valid = 1'b1;
      rx_in_data  = 8'hA5;
      #1;
      chk(!tx_out_valid && !tx_in_ready, "R6", "tx moves nothing", {tx_out_valid, tx_in_ready}, 0);
      chk(!rx_out_valid, "R6", "rx forwards nothing", rx_out_valid, 0);
      step();
      chk(!tx_reject && !rx_reject, "R6", "reject one cycle only", {tx_reject, rx_reject}, 0);
      chk(!tx_out_valid && !tx_busy, "R6", "tx still quiet", {tx_out_valid, tx_busy}, 0);
      tx_in_valid = 1'b0;
      rx_in_valid = 1'b0;
      cfg_len = LW'(0);
      cfg_csum_en = 1'b0;
      tx_start = 1'b1;
      step();
      tx_start = 1'b0;
      chk(tx_reject && !tx_busy, "R6", "zero length refused", {tx_reject, tx_busy}, 2);
      step();
   endtask

   task automatic rx_frame(input int n, input bit en, input bit corrupt, input bit ok_exp);
      logic [7:0] s;
      s = ref_sum(n);
      cfg_len = LW'(n);
      cfg_csum_en = en;
      rx_start = 1'b1;
      step();
      rx_start = 1'b0;
      chk(!rx_res_valid && rx_busy, "R8", "result cleared at start", {rx_res_valid, rx_busy}, 1);
      for (int i = 0; i < n; i++) begin
         rx_in_valid = 1'b1;
         rx_in_data  = pay[i];
         #1;
         chk(rx_out_valid && rx_out_data == pay[i], "R3", $sformatf("rx fwd byte %0d", i),
             rx_out_data, pay[i]);
         step();
         if (i == 0) begin
            rx_in_valid = 1'b0;
            step();
            chk(!rx_res_valid && rx_busy, "R8", "gap keeps frame open", {rx_res_valid, rx_busy}, 1);
         end
      end
      if (en) begin
         rx_in_valid = 1'b1;
         rx_in_data  = corrupt ? (s ^ 8'h01) : s;
         #1;
         chk(!rx_out_valid, "R3", "checksum byte not forwarded", rx_out_valid, 0);
         chk(!rx_res_valid, "R8", "no result before final byte", rx_res_valid, 0);
         step();
      end
      rx_in_valid = 1'b0;
      chk(rx_res_valid && !rx_busy, "R8", "result one cycle after final", {rx_res_valid, rx_busy}, 2);
      chk(rx_res_ok == ok_exp, en ? "R3" : "R4", "result flag", rx_res_ok, ok_exp);
      rx_in_valid = 1'b1;
      rx_in_data  = 8'h33;
      step();
      rx_in_valid = 1'b0;
      step();
      chk(rx_res_valid && rx_res_ok == ok_exp, "R8", "result held", {rx_res_valid, rx_res_ok},
          {1'b1, ok_exp});
   endtask

   initial begin
      reset_state();
      test_widths();

      fill(4, 8'h11, 8'h23);
      tx_frame(4, 1, 0);
      fill(3, 8'hC0, 8'h31);
      tx_frame(3, 0, 0);
      for (int i = 0; i < 31; i++) pay[i] = 8'hFF;
      tx_frame(31, 1, 0);
      fill(1, 8'h7E, 0);
      tx_frame(1, 1, 0);
      fill(4, 8'h05, 8'h17);
      tx_frame(4, 0, 1);

      test_tx_backpressure();
      test_reject();

      fill(5, 8'h90, 8'h2B);
      rx_frame(5, 1, 0, 1);
      rx_frame(5, 1, 1, 0);
      fill(6, 8'h01, 8'h55);
      rx_frame(6, 0, 0, 1);
      for (int i = 0; i < 31; i++) pay[i] = 8'hFF;
      rx_frame(31, 1, 0, 1);
      fill(1, 8'hE7, 0);
      rx_frame(1, 1, 0, 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
         $finish;
      end
   end

endmodule